// File: doc/BRIEF.md
# Status Byte Write-Protection Guard

This block keeps the protection part of a serial memory's status byte and decides, one request at a time, whether a status-byte write or an array-byte write may go ahead. A command controller presents the level of the write-protect pin, its write-enable latch and busy flags, a status-write request with its data byte, and an array-write request with its target address. The guard answers each request with a one-cycle response strobe and a grant flag. It also presents the readable status byte and the current protection mode.

Two stored size bits protect an upper fraction of the array: none, a quarter, a half or all of it. The fraction follows the address width parameter. A stored lock bit works together with the pin. When the lock is set and the pin is low, the status byte cannot be changed. Raising the pin lifts that lock again. While the controller reports a programming cycle as busy, the displayed lock and size bits hold their earlier values. The latch and busy bits in the status byte keep tracking the controller.

Top module: `wp_status_guard`

## Requirements
- R1: After reset the status byte reads 0x00 and the mode reads 0 (open).
- R2: Status byte layout: bit 7 lock, bits 6:4 always 0, bits 3:2 size code, bit 1 write-enable latch, bit 0 busy. Bits 1:0 show the latch and busy inputs one clock later.
- R3: While the lock bit is 0, a status write is granted when the latch input is 1, whatever the pin level. It is denied when the latch input is 0.
- R4: While the lock bit is 1 and the pin is low (hard mode), every status write is denied, even with the latch set. Hard mode is reached whether the lock is set first or the pin is lowered first.
- R5: Raising the pin leaves hard mode for soft mode. The size code is unchanged, and status writes with the latch set are granted again.
- R6: The size code selects the protected addresses of a 2^ADDR_W array. 00 protects none. 01 protects the top quarter (0x1800 to 0x1FFF at the default width). 10 protects the top half (0x1000 and up). 11 protects every address.
- R7: An array write is granted only when the latch input is 1 and the address lies outside the protected region.
- R8: A granted status write stores only data bits 7 and 3:2. Data bits 6:4 and 1:0 have no effect on the status byte.
- R9: While the busy input is 1, status bits 7 and 3:2 keep their displayed value. The stored value appears one clock after busy returns to 0.
- R10: A denied request changes no stored bit.
- R11: Each request gets a response strobe exactly one clock later, lasting one cycle. A grant is only ever reported together with that strobe.
- R12: Mode output: 2 (hard) when the lock is set and the pin is low, otherwise 1 (soft) when the lock is set or the size code is nonzero, otherwise 0 (open). It reflects the stored bits after the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_level_i | input | 1 | Write-protect pin level (low protects) |
| latch_i | input | 1 | Write-enable latch from controller |
| busy_i | input | 1 | Programming cycle in progress |
| sr_wr_req_i | input | 1 | Status write request |
| sr_wr_data_i | input | 8 | Status write data byte |
| arr_wr_req_i | input | 1 | Array write request |
| arr_wr_addr_i | input | ADDR_W | Array write address |
| status_o | output | 8 | Readable status byte |
| sr_resp_valid_o | output | 1 | Status write response strobe |
| sr_grant_o | output | 1 | Status write granted |
| arr_resp_valid_o | output | 1 | Array write response strobe |
| arr_grant_o | output | 1 | Array write granted |
| mode_o | output | 2 | Protection mode: 0 open, 1 soft, 2 hard |

## Verification
Every result comes from a flop, so the response strobes, the grant flags, the mode and bits 1:0 of the status byte are all due one clock after the edge that samples the request or input. The displayed lock and size bits follow the first edge at which busy is low. The bench changes inputs 1 ns after a rising edge and reads the directed results at the same offset after the next edge. Its behavioural model updates at each rising edge and is compared with every output at each falling edge, so no check ever lands on an edge.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [1:0] {
    MODE_OPEN = 2'd0,
    MODE_SOFT = 2'd1,
    MODE_HARD = 2'd2
  } prot_mode_e;

  localparam int unsigned SB_LOCK    = 7;
  localparam int unsigned SB_SIZE_HI = 3;
  localparam int unsigned SB_SIZE_LO = 2;
  localparam int unsigned SB_LATCH   = 1;
  localparam int unsigned SB_BUSY    = 0;

  function automatic prot_mode_e mode_of(logic lock, logic [1:0] size, logic pin_high);
    if (lock && !pin_high) return MODE_HARD;
    if (lock || (size != 2'b00)) return MODE_SOFT;
    return MODE_OPEN;
  endfunction
endpackage

// File: rtl/wpg_region_decode.sv
module wpg_region_decode #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              protected_o
);
  localparam int unsigned TOP = ADDR_W - 1;

  always_comb begin
    unique case (size_i)
      2'b00:   protected_o = 1'b0;
      2'b01:   protected_o = addr_i[TOP] & addr_i[TOP-1];
      2'b10:   protected_o = addr_i[TOP];
      default: protected_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpg_status_store.sv
module wpg_status_store (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en_i,
  input  logic       wr_lock_i,
  input  logic [1:0] wr_size_i,
  input  logic       busy_i,
  output logic       lock_q,
  output logic [1:0] size_q,
  output logic       shown_lock_q,
  output logic [1:0] shown_size_q
);
  logic       next_lock;
  logic [1:0] next_size;

  always_comb begin
    next_lock = wr_en_i ? wr_lock_i : lock_q;
    next_size = wr_en_i ? wr_size_i : size_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q       <= 1'b0;
      size_q       <= 2'b00;
      shown_lock_q <= 1'b0;
      shown_size_q <= 2'b00;
    end else begin
      lock_q <= next_lock;
      size_q <= next_size;
      if (!busy_i) begin
        shown_lock_q <= next_lock;
        shown_size_q <= next_size;
      end
    end
  end

  // R10: nothing stored moves without a write enable
  p_deny_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable({lock_q, size_q}));

  // R9: displayed bits hold across a busy edge
  p_freeze_shown_r9: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> $stable({shown_lock_q, shown_size_q}));
endmodule

// File: rtl/wp_status_guard.sv
module wp_status_guard
  import wpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_level_i,
  input  logic              latch_i,
  input  logic              busy_i,
  input  logic              sr_wr_req_i,
  input  logic [7:0]        sr_wr_data_i,
  input  logic              arr_wr_req_i,
  input  logic [ADDR_W-1:0] arr_wr_addr_i,
  output logic [7:0]        status_o,
  output logic              sr_resp_valid_o,
  output logic              sr_grant_o,
  output logic              arr_resp_valid_o,
  output logic              arr_grant_o,
  output logic [1:0]        mode_o
);
  logic       lock_q, shown_lock_q;
  logic [1:0] size_q, shown_size_q;
  logic       addr_protected;
  logic       hard_lock, sr_ok, arr_ok;
  logic       latch_q, busy_q;
  logic       wr_lock;
  logic [1:0] wr_size;
  prot_mode_e mode_q, mode_next;
  logic       unused_data_bits;

  assign wr_lock          = sr_wr_data_i[SB_LOCK];
  assign wr_size          = sr_wr_data_i[SB_SIZE_HI:SB_SIZE_LO];
  assign unused_data_bits = ^{sr_wr_data_i[6:4], sr_wr_data_i[1:0]};

  wpg_region_decode #(.ADDR_W(ADDR_W)) u_region (
    .size_i      (size_q),
    .addr_i      (arr_wr_addr_i),
    .protected_o (addr_protected)
  );

  always_comb begin
    hard_lock = lock_q & ~wp_level_i;
    sr_ok     = sr_wr_req_i & latch_i & ~hard_lock;
    arr_ok    = arr_wr_req_i & latch_i & ~addr_protected;
    mode_next = mode_of(sr_ok ? wr_lock : lock_q,
                        sr_ok ? wr_size : size_q, wp_level_i);
  end

  wpg_status_store u_store (
    .clk          (clk),
    .rst          (rst),
    .wr_en_i      (sr_ok),
    .wr_lock_i    (wr_lock),
    .wr_size_i    (wr_size),
    .busy_i       (busy_i),
    .lock_q       (lock_q),
    .size_q       (size_q),
    .shown_lock_q (shown_lock_q),
    .shown_size_q (shown_size_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_resp_valid_o  <= 1'b0;
      sr_grant_o       <= 1'b0;
      arr_resp_valid_o <= 1'b0;
      arr_grant_o      <= 1'b0;
      latch_q          <= 1'b0;
      busy_q           <= 1'b0;
      mode_q           <= MODE_OPEN;
    end else begin
      sr_resp_valid_o  <= sr_wr_req_i;
      sr_grant_o       <= sr_ok;
      arr_resp_valid_o <= arr_wr_req_i;
      arr_grant_o      <= arr_ok;
      latch_q          <= latch_i;
      busy_q           <= busy_i;
      mode_q           <= mode_next;
    end
  end

  always_comb begin
    status_o             = 8'h00;
    status_o[SB_LOCK]    = shown_lock_q;
    status_o[SB_SIZE_HI] = shown_size_q[1];
    status_o[SB_SIZE_LO] = shown_size_q[0];
    status_o[SB_LATCH]   = latch_q;
    status_o[SB_BUSY]    = busy_q;
  end
  assign mode_o = mode_q;

  // R4: hard mode refuses status writes
  p_hard_denies_r4: assert property (@(posedge clk) disable iff (rst)
    (sr_wr_req_i && lock_q && !wp_level_i) |=> (sr_resp_valid_o && !sr_grant_o));

  // R3: no latch, no status write
  p_sr_needs_latch_r3: assert property (@(posedge clk) disable iff (rst)
    (sr_wr_req_i && !latch_i) |=> !sr_grant_o);

  // R7: no latch, no array write
  p_arr_needs_latch_r7: assert property (@(posedge clk) disable iff (rst)
    (arr_wr_req_i && !latch_i) |=> !arr_grant_o);

  // R6: full protection refuses every address
  p_whole_array_r6: assert property (@(posedge clk) disable iff (rst)
    (arr_wr_req_i && size_q == 2'b11) |=> (arr_resp_valid_o && !arr_grant_o));

  // R11: strobes follow a request and grants ride on strobes
  p_sr_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    sr_resp_valid_o |-> $past(sr_wr_req_i));
  p_grant_on_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    (sr_grant_o |-> sr_resp_valid_o) and (arr_grant_o |-> arr_resp_valid_o));
endmodule

// File: tb/wp_status_guard_bench.sv
`timescale 1ns/1ps
module wp_status_guard_bench;
  localparam int AW = 13;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp = 1'b1, latch = 1'b0, busy = 1'b0;
  logic sr_req = 1'b0, arr_req = 1'b0;
  logic [7:0] sr_data = 8'h00;
  logic [AW-1:0] addr = '0;
  logic [7:0] status;
  logic sr_v, sr_g, ar_v, ar_g;
  logic [1:0] mode;

  int checks = 0, fails = 0;
  bit started = 1'b0;

  // behavioural reference state
  int m_lock, m_size, m_slock, m_ssize, m_latch, m_busy, m_mode;
  int m_srv, m_srg, m_arv, m_arg;

  always #2 clk = ~clk;

  wp_status_guard #(.ADDR_W(AW)) u_wp_status_guard (
    .clk(clk), .rst(rst), .wp_level_i(wp), .latch_i(latch), .busy_i(busy),
    .sr_wr_req_i(sr_req), .sr_wr_data_i(sr_data), .arr_wr_req_i(arr_req),
    .arr_wr_addr_i(addr), .status_o(status), .sr_resp_valid_o(sr_v),
    .sr_grant_o(sr_g), .arr_resp_valid_o(ar_v), .arr_grant_o(ar_g), .mode_o(mode)
  );

  function automatic int in_region(int size, int a);
    case (size)
      1: return (a >= (DEPTH * 3) / 4) ? 1 : 0;
      2: return (a >= DEPTH / 2) ? 1 : 0;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_lock = 0; m_size = 0; m_slock = 0; m_ssize = 0; m_latch = 0; m_busy = 0;
      m_mode = 0; m_srv = 0; m_srg = 0; m_arv = 0; m_arg = 0;
    end else begin
      int hard, sok, aok, nl, ns;
      hard = (m_lock == 1 && !wp) ? 1 : 0;
      sok  = (sr_req && latch && hard == 0) ? 1 : 0;
      aok  = (arr_req && latch && in_region(m_size, int'(addr)) == 0) ? 1 : 0;
      nl   = sok ? int'(sr_data[7]) : m_lock;
      ns   = sok ? int'(sr_data[3:2]) : m_size;
      if (!busy) begin m_slock = nl; m_ssize = ns; end
      m_lock = nl; m_size = ns;
      m_mode = (nl == 1 && !wp) ? 2 : ((nl == 1 || ns != 0) ? 1 : 0);
      m_latch = int'(latch); m_busy = int'(busy);
      m_srv = int'(sr_req); m_srg = sok; m_arv = int'(arr_req); m_arg = aok;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R2 status byte vs model", int'(status),
          (m_slock << 7) | (m_ssize << 2) | (m_latch << 1) | m_busy);
      chk("R11 status strobe vs model", int'(sr_v), m_srv);
      chk("R3 status grant vs model", int'(sr_g), m_srg);
      chk("R11 array strobe vs model", int'(ar_v), m_arv);
      chk("R7 array grant vs model", int'(ar_g), m_arg);
      chk("R12 mode vs model", int'(mode), m_mode);
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic sr_write(logic [7:0] d);
    sr_req = 1'b1; sr_data = d; cyc(); sr_req = 1'b0;
  endtask

  task automatic arr_write(int a);
    arr_req = 1'b1; addr = AW'(a); cyc(); arr_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0; started = 1'b1;
    cyc();
    chk("R1 reset status", int'(status), 8'h00);
    chk("R1 reset mode", int'(mode), 0);

    // R3 latch clear: denied, nothing stored (R10)
    wp = 1'b0; latch = 1'b0;
    sr_write(8'h04);
    chk("R3 deny without latch strobe", int'(sr_v), 1);
    chk("R3 deny without latch", int'(sr_g), 0);
    cyc();
    chk("R11 strobe lasts one cycle", int'(sr_v), 0);
    chk("R10 denied write stores nothing", int'(status), 8'h00);

    // R3 lock clear, pin low, latch set: granted
    latch = 1'b1;
    sr_write(8'h04);
    chk("R3 grant with pin low", int'(sr_g), 1);
    chk("R12 soft mode from size", int'(mode), 1);
    chk("R2 layout size 01 latch", int'(status), 8'h06);

    // R6 quarter boundary, R7 unprotected grant
    arr_write(16'h17FF);
    chk("R7 below quarter granted", int'(ar_g), 1);
    arr_write(16'h1800);
    chk("R6 quarter start denied", int'(ar_g), 0);
    chk("R6 quarter strobe", int'(ar_v), 1);

    // R8 ignored data bits; R4 pin low first then lock
    sr_write(8'hF8);
    chk("R8 only lock and size stored", int'(status), 8'h8A);
    chk("R4 hard after lock with pin low", int'(mode), 2);
    sr_write(8'h00);
    chk("R4 hard mode denies", int'(sr_g), 0);
    cyc();
    chk("R10 hard deny keeps byte", int'(status), 8'h8A);

    // R6 half region
    arr_write(16'h0FFF);
    chk("R6 below half granted", int'(ar_g), 1);
    arr_write(16'h1000);
    chk("R6 half start denied", int'(ar_g), 0);

    // R5 raise pin
    wp = 1'b1; cyc();
    chk("R5 soft after pin raised", int'(mode), 1);
    chk("R5 size unchanged", int'(status), 8'h8A);
    sr_write(8'h8C);
    chk("R5 write granted again", int'(sr_g), 1);
    chk("R2 layout lock size 11", int'(status), 8'h8E);
    arr_write(0);
    chk("R6 whole array denied", int'(ar_g), 0);

    // R4 lock first, then pin low
    wp = 1'b0; cyc();
    chk("R4 hard after pin lowered", int'(mode), 2);
    sr_write(8'h00);
    chk("R4 denied in hard mode", int'(sr_g), 0);
    wp = 1'b1;
    sr_write(8'h00);
    chk("R5 cleared after pin high", int'(status), 8'h02);
    chk("R12 open mode", int'(mode), 0);

    // R7 latch clear
    latch = 1'b0;
    arr_write(0);
    chk("R7 no latch denied", int'(ar_g), 0);

    // R9 freeze while busy
    latch = 1'b1; busy = 1'b1;
    sr_write(8'h0C);
    chk("R9 grant during busy", int'(sr_g), 1);
    chk("R9 frozen display", int'(status), 8'h03);
    cyc(); cyc();
    chk("R9 still frozen", int'(status), 8'h03);
    chk("R12 mode uses stored bits", int'(mode), 1);
    busy = 1'b0; cyc();
    chk("R9 released display", int'(status), 8'h0E);

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      wp      = ($urandom % 4) != 0;
      latch   = ($urandom % 3) != 0;
      busy    = ($urandom % 4) == 0;
      sr_req  = ($urandom % 3) == 0;
      sr_data = 8'($urandom);
      arr_req = ($urandom % 2) == 0;
      addr    = AW'($urandom);
      cyc();
    end
    sr_req = 1'b0; arr_req = 1'b0;
    cyc(); cyc();
    finish_run();
  end
endmodule